// File: doc/BRIEF.md
# Configurable Audio Serial Receiver

This block takes a serial audio stream made of a bit clock, a word-select line and a data line, all sampled by the system clock. It turns the stream into parallel sample words. Each word comes out on a one-cycle valid strobe, together with the index of the slot it belongs to.

Two framing schemes are supported:
- **Two-channel framing.** Each level of word-select carries one channel.
- **Time-division framing.** A word-select pulse opens a frame of up to sixteen back-to-back slots.

Software sets these options through static configuration inputs:
- the sample width;
- which word-select level marks the first channel;
- the bit order;
- an optional one-bit-clock data delay;
- the mono channel choice;
- 24-to-32 padding;
- per-slot enables in time-division framing.

Capture begins at the first frame start after the start input goes high. A word counter raises an end-of-frame pulse after a programmed number of words. A two-bit stop policy decides whether that pulse, or a buffer-full indication from downstream, also halts capture.

Top module: `aud_rx_core`

## Requirements
- R1: The width field holds sample width minus one. The values 7, 15, 23 and 31 give 8-, 16-, 24- and 32-bit samples. Each sample leaves right-aligned in `out_data_o` with zeros above it, and bits of a slot beyond the width are ignored.
- R2: In two-channel framing, slot 0 is the channel received while word-select equals `ws_pol_i` and slot 1 is the other. A transition of word-select into the `ws_pol_i` level starts a frame.
- R3: With `lsb_first_i` at 0 the first received bit of a slot is the sample MSB. At 1 it is the sample LSB.
- R4: With `delay_en_i` at 1 the first data bit of a slot arrives one bit clock after the word-select transition. At 0 it arrives on the same bit clock. Data and word-select are sampled on rising bit-clock edges.
- R5: In time-division framing, slots of width bits follow one another from the frame start, for `slot_last_i`+1 slots. An enabled slot (bit n of `slot_en_i`) delivers its data. A disabled slot still produces a valid word, with data 0.
- R6: `eof_o` pulses together with the valid of every (`eof_count_i`+1)-th delivered word, that is after (width field + 1) × (count + 1) bits. The word count then restarts.
- R7: Stop mode 0 (and 3) halts capture only when `start_i` falls. `buf_full_i` and the end-of-frame pulse have no effect on it.
- R8: Stop mode 1 also halts capture after the word that carries `eof_o`. No further words appear until `start_i` is dropped and raised again.
- R9: Stop mode 2 also halts capture when a word completes while `buf_full_i` is high. That word is dropped.
- R10: In two-channel framing with `mono_en_i` set, only slot 0 (`mono_first_i` = 1) or only slot 1 (`mono_first_i` = 0) is delivered.
- R11: With a 24-bit width and `fill_i` set, the sample is padded to 32 bits by placing it in bits 31:8 with bits 7:0 zero. Otherwise 24-bit samples stay in bits 23:0.
- R12: After reset `out_valid_o`, `eof_o`, `out_data_o` and `out_slot_o` are 0. Words completed before the first frame start after `start_i` rises are not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, sampled by clk |
| ws_i | input | 1 | Word-select / frame line |
| sd_i | input | 1 | Serial data |
| start_i | input | 1 | Capture enable, level |
| tdm_en_i | input | 1 | 1: time-division framing, 0: two-channel |
| width_m1_i | input | 5 | Sample width minus one |
| ws_pol_i | input | 1 | Word-select level of the first channel |
| lsb_first_i | input | 1 | Bit order, 1 = LSB first |
| delay_en_i | input | 1 | One-bit-clock data delay |
| slot_last_i | input | 4 | Slot count minus one in time-division framing |
| slot_en_i | input | 16 | Per-slot capture enable |
| mono_en_i | input | 1 | Deliver one channel only |
| mono_first_i | input | 1 | Mono keeps slot 0 when 1, slot 1 when 0 |
| fill_i | input | 1 | Pad 24-bit samples to 32 bits |
| stop_mode_i | input | 2 | Stop policy |
| eof_count_i | input | 12 | Words per end-of-frame event minus one |
| buf_full_i | input | 1 | Downstream buffer full |
| out_valid_o | output | 1 | Word strobe |
| out_data_o | output | 32 | Received word |
| out_slot_o | output | 4 | Slot index of the word |
| eof_o | output | 1 | End-of-frame event |

## Verification
The bench sweeps every legal width in both bit orders, with and without the data delay, and under both word-select polarities.

Each corner case is aimed at a specific fault:
- **Delay and polarity handling.** A design that mishandled either would shift every sample by one bit, or swap the two channels.
- **Disabled time-division slots.** A design that dropped these slots instead of zeroing them would renumber the slots that follow.
- **Slot overrun.** Slot lengths longer than the width expose a design that keeps shifting past the sample end.
- **End-of-frame counting.** The count is checked across two periods, so an off-by-one or a counter that never restarts shows up as a misplaced pulse.
- **Stop policies.** These are exercised at word boundaries. A design that ignored a policy would keep delivering, and one that applied a policy in the wrong mode would stop early.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
   // One bit-clock event as seen by the deserializer
   typedef struct packed {
      logic stb;   // rising bit-clock edge seen
      logic sd;    // data bit captured at that edge
      logic fe;    // frame start (entry into first-channel level)
      logic ce;    // entry into second-channel level
   } rx_evt_t;

   localparam int FILL_SHIFT = 8;
   localparam int FILL_WIDTH_M1 = 23;
endpackage

// File: rtl/aud_rx_sampler.sv
module aud_rx_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                ws_i,
   input  logic                sd_i,
   input  logic                ws_pol_i,
   input  logic                delay_en_i,
   output aud_rx_pkg::rx_evt_t evt_o
);
   localparam int CW = 3 * SYNC_STAGES;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("aud_rx_sampler: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] chain_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {bclk_i, ws_i, sd_i};
         end
      end else begin : g_sync_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CW-4:0], bclk_i, ws_i, sd_i};
         end
      end
   endgenerate

   logic bclk_s, ws_s, sd_s, bclk_q, rise;
   logic ws_h1_q, ws_h2_q, ws_eff, ws_eff_prev;

   assign bclk_s = chain_q[CW-1];
   assign ws_s   = chain_q[CW-2];
   assign sd_s   = chain_q[CW-3];
   assign rise   = bclk_s & ~bclk_q;

   always_comb begin
      ws_eff      = delay_en_i ? ws_h1_q : ws_s;
      ws_eff_prev = delay_en_i ? ws_h2_q : ws_h1_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q  <= 1'b0;
         ws_h1_q <= 1'b0;
         ws_h2_q <= 1'b0;
         evt_o   <= '0;
      end else begin
         bclk_q <= bclk_s;
         evt_o  <= '0;
         if (rise) begin
            ws_h1_q   <= ws_s;
            ws_h2_q   <= ws_h1_q;
            evt_o.stb <= 1'b1;
            evt_o.sd  <= sd_s;
            evt_o.fe  <= (ws_eff == ws_pol_i) && (ws_eff_prev != ws_pol_i);
            evt_o.ce  <= (ws_eff != ws_pol_i) && (ws_eff_prev == ws_pol_i);
         end
      end
   end

   // A rising edge needs the synchronized clock low first, so strobes never abut
   p_single_strobe_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.stb |=> !evt_o.stb);
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser #(
   parameter int MAX_W = 32,
   parameter int SLOTS = 16,
   localparam int BCNT_W = $clog2(MAX_W),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  aud_rx_pkg::rx_evt_t evt_i,
   input  logic                tdm_en_i,
   input  logic                lsb_first_i,
   input  logic [BCNT_W-1:0]   width_m1_i,
   input  logic [SLOT_W-1:0]   slot_last_i,
   output logic                word_vld_o,
   output logic [MAX_W-1:0]    word_o,
   output logic [SLOT_W-1:0]   word_slot_o
);
   logic [BCNT_W-1:0] bit_cnt_q, bit_idx, pos;
   logic [SLOT_W-1:0] slot_q, slot_cur;
   logic              busy_q, ce_std, take, last_bit;
   logic [MAX_W-1:0]  acc_q, acc_base, acc_next;

   always_comb begin
      ce_std   = evt_i.ce & ~tdm_en_i;
      take     = evt_i.stb & (evt_i.fe | ce_std | busy_q);
      bit_idx  = (evt_i.fe | ce_std) ? '0 : bit_cnt_q;
      slot_cur = evt_i.fe ? '0 : (ce_std ? SLOT_W'(1) : slot_q);
      pos      = lsb_first_i ? bit_idx : (width_m1_i - bit_idx);
      acc_base = (bit_idx == '0) ? '0 : acc_q;
      acc_next = acc_base | (MAX_W'(evt_i.sd) << pos);
      last_bit = (bit_idx == width_m1_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q   <= '0;
         slot_q      <= '0;
         busy_q      <= 1'b0;
         acc_q       <= '0;
         word_vld_o  <= 1'b0;
         word_o      <= '0;
         word_slot_o <= '0;
      end else begin
         word_vld_o <= 1'b0;
         if (take) begin
            acc_q <= acc_next;
            if (last_bit) begin
               word_vld_o  <= 1'b1;
               word_o      <= acc_next;
               word_slot_o <= slot_cur;
               bit_cnt_q   <= '0;
               if (tdm_en_i && (slot_cur != slot_last_i)) begin
                  slot_q <= slot_cur + SLOT_W'(1);
                  busy_q <= 1'b1;
               end else begin
                  slot_q <= slot_cur;
                  busy_q <= 1'b0;
               end
            end else begin
               bit_cnt_q <= bit_idx + BCNT_W'(1);
               slot_q    <= slot_cur;
               busy_q    <= 1'b1;
            end
         end
      end
   end

   // No bit of a finished word lies above the configured width
   p_word_fits_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |-> ((word_o >> width_m1_i) <= MAX_W'(1)));
endmodule

// File: rtl/aud_rx_fmt.sv
module aud_rx_fmt #(
   parameter int MAX_W = 32,
   parameter int SLOTS = 16,
   localparam int BCNT_W = $clog2(MAX_W),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic [MAX_W-1:0]  word_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              tdm_en_i,
   input  logic [SLOTS-1:0]  slot_en_i,
   input  logic              mono_en_i,
   input  logic              mono_first_i,
   input  logic              fill_i,
   input  logic [BCNT_W-1:0] width_m1_i,
   output logic              keep_o,
   output logic [MAX_W-1:0]  data_o
);
   logic zero_slot;

   always_comb begin
      zero_slot = tdm_en_i & ~slot_en_i[slot_i];
      if (tdm_en_i || !mono_en_i) keep_o = 1'b1;
      else keep_o = (slot_i == (mono_first_i ? SLOT_W'(0) : SLOT_W'(1)));
   end

   generate
      if (MAX_W >= 32) begin : g_with_fill
         always_comb begin
            if (zero_slot) data_o = '0;
            else if (fill_i && (width_m1_i == BCNT_W'(aud_rx_pkg::FILL_WIDTH_M1)))
               data_o = word_i << aud_rx_pkg::FILL_SHIFT;
            else data_o = word_i;
         end
      end else begin : g_no_fill
         logic unused_fill;
         assign unused_fill = fill_i;
         always_comb data_o = zero_slot ? '0 : word_i;
      end
   endgenerate
endmodule

// File: rtl/aud_rx_core.sv
module aud_rx_core #(
   parameter int MAX_W       = 32,
   parameter int SLOTS       = 16,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2,
   localparam int BCNT_W = $clog2(MAX_W),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_i,
   input  logic              ws_i,
   input  logic              sd_i,
   input  logic              start_i,
   input  logic              tdm_en_i,
   input  logic [BCNT_W-1:0] width_m1_i,
   input  logic              ws_pol_i,
   input  logic              lsb_first_i,
   input  logic              delay_en_i,
   input  logic [SLOT_W-1:0] slot_last_i,
   input  logic [SLOTS-1:0]  slot_en_i,
   input  logic              mono_en_i,
   input  logic              mono_first_i,
   input  logic              fill_i,
   input  logic [1:0]        stop_mode_i,
   input  logic [CNT_W-1:0]  eof_count_i,
   input  logic              buf_full_i,
   output logic              out_valid_o,
   output logic [MAX_W-1:0]  out_data_o,
   output logic [SLOT_W-1:0] out_slot_o,
   output logic              eof_o
);
   generate
      if (MAX_W < 8 || (1 << BCNT_W) != MAX_W) begin : g_bad_width
         $error("aud_rx_core: MAX_W must be a power of two of at least 8");
      end
      if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
         $error("aud_rx_core: SLOTS must be a power of two of at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("aud_rx_core: CNT_W must be positive");
      end
   endgenerate

   localparam logic [1:0] STOP_ON_EOF  = 2'd1;
   localparam logic [1:0] STOP_ON_FULL = 2'd2;

   aud_rx_pkg::rx_evt_t evt;
   logic                word_vld, keep;
   logic [MAX_W-1:0]    word, fmt_data;
   logic [SLOT_W-1:0]   word_slot;

   aud_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
      .ws_pol_i(ws_pol_i), .delay_en_i(delay_en_i), .evt_o(evt)
   );

   aud_rx_deser #(.MAX_W(MAX_W), .SLOTS(SLOTS)) u_deser (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .tdm_en_i(tdm_en_i),
      .lsb_first_i(lsb_first_i), .width_m1_i(width_m1_i), .slot_last_i(slot_last_i),
      .word_vld_o(word_vld), .word_o(word), .word_slot_o(word_slot)
   );

   aud_rx_fmt #(.MAX_W(MAX_W), .SLOTS(SLOTS)) u_fmt (
      .word_i(word), .slot_i(word_slot), .tdm_en_i(tdm_en_i), .slot_en_i(slot_en_i),
      .mono_en_i(mono_en_i), .mono_first_i(mono_first_i), .fill_i(fill_i),
      .width_m1_i(width_m1_i), .keep_o(keep), .data_o(fmt_data)
   );

   logic             active_q, halted_q, synced_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cand, full_drop, emit, hit, stop_evt;

   always_comb begin
      cand      = word_vld & keep & active_q & synced_q;
      full_drop = cand & buf_full_i & (stop_mode_i == STOP_ON_FULL);
      emit      = cand & ~full_drop;
      hit       = emit & (cnt_q == eof_count_i);
      stop_evt  = full_drop | (hit & (stop_mode_i == STOP_ON_EOF));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         halted_q <= 1'b0;
         synced_q <= 1'b0;
      end else if (!start_i) begin
         active_q <= 1'b0;
         halted_q <= 1'b0;
         synced_q <= 1'b0;
      end else if (stop_evt) begin
         active_q <= 1'b0;
         halted_q <= 1'b1;
      end else begin
         if (!halted_q) active_q <= 1'b1;
         if (active_q && evt.stb && evt.fe) synced_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
         out_slot_o  <= '0;
         eof_o       <= 1'b0;
      end else begin
         out_valid_o <= emit;
         eof_o       <= hit;
         if (emit) begin
            out_data_o <= fmt_data;
            out_slot_o <= word_slot;
         end
         if (!active_q) cnt_q <= '0;
         else if (hit) cnt_q <= '0;
         else if (emit) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   p_eof_with_valid_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      eof_o |-> out_valid_o);

   p_std_slot_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !tdm_en_i) |-> (out_slot_o <= SLOT_W'(1)));

   p_slot_range_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && tdm_en_i) |-> (out_slot_o <= slot_last_i));

   p_zero_slot_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && tdm_en_i && !slot_en_i[out_slot_o]) |-> (out_data_o == '0));

   p_halt_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(halted_q) |-> !out_valid_o);
endmodule

// File: tb/aud_rx_core_bench.sv
module aud_rx_core_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bclk = 1'b0, ws = 1'b0, sd = 1'b0, start = 1'b0;
   logic tdm_en = 1'b0, ws_pol = 1'b0, lsb_first = 1'b0, delay_en = 1'b0;
   logic [4:0] width_m1 = 5'd15;
   logic [3:0] slot_last = 4'd0;
   logic [15:0] slot_en = 16'hFFFF;
   logic mono_en = 1'b0, mono_first = 1'b1, fill = 1'b0, buf_full = 1'b0;
   logic [1:0] stop_mode = 2'd0;
   logic [11:0] eof_count = 12'd64;
   logic out_valid, eof;
   logic [31:0] out_data;
   logic [3:0] out_slot;

   always #5 clk = ~clk;

   aud_rx_core u_aud_rx_core (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .ws_i(ws), .sd_i(sd), .start_i(start),
      .tdm_en_i(tdm_en), .width_m1_i(width_m1), .ws_pol_i(ws_pol), .lsb_first_i(lsb_first),
      .delay_en_i(delay_en), .slot_last_i(slot_last), .slot_en_i(slot_en),
      .mono_en_i(mono_en), .mono_first_i(mono_first), .fill_i(fill),
      .stop_mode_i(stop_mode), .eof_count_i(eof_count), .buf_full_i(buf_full),
      .out_valid_o(out_valid), .out_data_o(out_data), .out_slot_o(out_slot), .eof_o(eof)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   // captured words
   logic [31:0] mon_d [256];
   logic [3:0]  mon_s [256];
   logic        mon_e [256];
   int mon_n = 0;
   // expected words
   logic [31:0] exp_d [256];
   logic [3:0]  exp_s [256];
   logic        exp_e [256];
   int exp_n = 0, base = 0;
   // bit stream
   logic ws_arr [2048];
   logic sd_arr [2048];
   int len = 0;
   logic [31:0] slot_w [16];

   always @(negedge clk) begin
      if (rst_n && out_valid && mon_n < 256) begin
         mon_d[mon_n] = out_data;
         mon_s[mon_n] = out_slot;
         mon_e[mon_n] = eof;
         mon_n = mon_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   function automatic logic [31:0] fmtw(input logic [31:0] w, input int W, input bit f);
      logic [31:0] v;
      v = (W == 32) ? w : (w & ((32'd1 << W) - 32'd1));
      if (f && W == 24) v = v << 8;
      return v;
   endfunction

   task automatic restart();
      start = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 2048; i++) begin ws_arr[i] = 1'b0; sd_arr[i] = 1'b0; end
      len = 0;
      exp_n = 0;
      base = mon_n;
      start = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic put(input int n, input logic w);
      for (int i = 0; i < n; i++) ws_arr[len + i] = w;
      len += n;
   endtask

   task automatic set_bits(input int p, input int W, input logic [31:0] w, input bit lsb);
      for (int j = 0; j < W; j++) sd_arr[p + j] = lsb ? w[j] : w[W - 1 - j];
   endtask

   task automatic add_std(input int W, input int L, input logic [31:0] w0, input logic [31:0] w1);
      int b;
      b = len;
      put(L, ws_pol);
      put(L, !ws_pol);
      set_bits(b + int'(delay_en), W, w0, lsb_first);
      set_bits(b + L + int'(delay_en), W, w1, lsb_first);
   endtask

   task automatic add_tdm(input int W, input int N);
      int b;
      b = len;
      put(1, ws_pol);
      put(N * W + 1, !ws_pol);
      for (int k = 0; k < N; k++) set_bits(b + int'(delay_en) + k * W, W, slot_w[k], lsb_first);
   endtask

   task automatic expect_w(input logic [31:0] d, input logic [3:0] s, input logic e);
      exp_d[exp_n] = d; exp_s[exp_n] = s; exp_e[exp_n] = e;
      exp_n++;
   endtask

   task automatic play();
      for (int i = 0; i < len; i++) begin
         ws = ws_arr[i]; sd = sd_arr[i];
         repeat (4) @(negedge clk);
         bclk = 1'b1;
         repeat (4) @(negedge clk);
         bclk = 1'b0;
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic compare(input string req);
      int got;
      got = mon_n - base;
      chk(got == exp_n, {req, " word count"}, got, exp_n);
      for (int i = 0; i < exp_n && i < got; i++) begin
         chk(mon_d[base + i] == exp_d[i], {req, " data"}, mon_d[base + i], exp_d[i]);
         chk(mon_s[base + i] == exp_s[i], {req, " slot"}, mon_s[base + i], exp_s[i]);
         chk(mon_e[base + i] == exp_e[i], {req, " eof"}, mon_e[base + i], exp_e[i]);
      end
   endtask

   // Two-channel run: nf frames, slot length L, expected words generated arithmetically
   task automatic run_std(input int W, input int L, input int nf, input logic [31:0] seed, input string req);
      restart();
      put(4, !ws_pol);
      for (int f = 0; f < nf; f++) begin
         logic [31:0] a, c;
         a = seed + 32'h9E37_79B9 * (2 * f);
         c = seed + 32'h9E37_79B9 * (2 * f + 1);
         add_std(W, L, a, c);
         if (!mono_en || mono_first) expect_w(fmtw(a, W, fill), 4'd0, 1'b0);
         if (!mono_en || !mono_first) expect_w(fmtw(c, W, fill), 4'd1, 1'b0);
      end
      put(3, !ws_pol);
      play();
      compare(req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(out_valid == 1'b0, "R12 reset valid", out_valid, 0);
      chk(eof == 1'b0, "R12 reset eof", eof, 0);
      chk(out_data == 32'd0, "R12 reset data", out_data, 0);
      chk(out_slot == 4'd0, "R12 reset slot", out_slot, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 R2 R3 R4: widths x bit order x delay x polarity
      for (int wi = 0; wi < 4; wi++) begin
         for (int m = 0; m < 8; m++) begin
            width_m1  = 5'(8 * wi + 7);
            lsb_first = m[0];
            delay_en  = m[1];
            ws_pol    = m[2];
            run_std(8 * wi + 8, 8 * wi + 10, 2, 32'hC3A5_1E0F + 32'(m * 77 + wi),
                    "R1/R2/R3/R4 std sweep");
         end
      end

      // R11: 24-bit with and without padding
      width_m1 = 5'd23; lsb_first = 1'b0; delay_en = 1'b1; ws_pol = 1'b0;
      fill = 1'b1;
      run_std(24, 26, 2, 32'h00AB_CDEF, "R11 fill on");
      fill = 1'b0;
      run_std(24, 26, 2, 32'h0012_3456, "R11 fill off");

      // R10: mono selection
      width_m1 = 5'd15; mono_en = 1'b1;
      mono_first = 1'b1;
      run_std(16, 18, 3, 32'h0000_7A11, "R10 mono first");
      mono_first = 1'b0;
      run_std(16, 18, 3, 32'h0000_3B22, "R10 mono second");
      mono_en = 1'b0; mono_first = 1'b1;

      // R5: time-division, 4 slots, slot 2 disabled, delayed, MSB first
      tdm_en = 1'b1; width_m1 = 5'd15; slot_last = 4'd3; slot_en = 16'hFFFB;
      delay_en = 1'b1; ws_pol = 1'b0; lsb_first = 1'b0;
      restart();
      put(4, !ws_pol);
      for (int f = 0; f < 2; f++) begin
         for (int k = 0; k < 4; k++) begin
            slot_w[k] = 32'h0000_1111 * (k + 1) + 32'(f * 16'h0101);
            expect_w(slot_en[k] ? (slot_w[k] & 32'hFFFF) : 32'd0, 4'(k), 1'b0);
         end
         add_tdm(16, 4);
      end
      put(3, !ws_pol);
      play();
      compare("R5 tdm 4 slots");

      // R5 R3: 16 slots of 8 bits, sparse enables, LSB first, no delay, high polarity
      width_m1 = 5'd7; slot_last = 4'd15; slot_en = 16'h5A5A;
      delay_en = 1'b0; ws_pol = 1'b1; lsb_first = 1'b1;
      restart();
      put(4, !ws_pol);
      for (int k = 0; k < 16; k++) begin
         slot_w[k] = 32'(8'h3C + k * 8'h17);
         expect_w(slot_en[k] ? (slot_w[k] & 32'hFF) : 32'd0, 4'(k), 1'b0);
      end
      add_tdm(8, 16);
      put(3, !ws_pol);
      play();
      compare("R5 tdm 16 slots");
      tdm_en = 1'b0; slot_en = 16'hFFFF; slot_last = 4'd0; ws_pol = 1'b0; lsb_first = 1'b0;

      // R6 R7: end-of-frame every 5 words in stop mode 0, buffer-full ignored
      width_m1 = 5'd7; stop_mode = 2'd0; eof_count = 12'd4; buf_full = 1'b1;
      restart();
      put(4, !ws_pol);
      for (int f = 0; f < 6; f++) begin
         logic [31:0] a, c;
         a = 32'(8'h10 + f * 2); c = 32'(8'h11 + f * 2);
         add_std(8, 10, a, c);
         expect_w(a, 4'd0, (2 * f == 4) || (2 * f == 9));
         expect_w(c, 4'd1, (2 * f + 1 == 4) || (2 * f + 1 == 9));
      end
      put(3, !ws_pol);
      play();
      compare("R6/R7 eof period, mode 0");
      buf_full = 1'b0;

      // R8: stop mode 1 halts after the eof word
      stop_mode = 2'd1; eof_count = 12'd2;
      restart();
      put(4, !ws_pol);
      for (int f = 0; f < 4; f++) begin
         logic [31:0] a, c;
         a = 32'(8'h40 + f * 2); c = 32'(8'h41 + f * 2);
         add_std(8, 10, a, c);
         if (2 * f < 3) expect_w(a, 4'd0, 2 * f == 2);
         if (2 * f + 1 < 3) expect_w(c, 4'd1, 1'b0);
      end
      put(3, !ws_pol);
      play();
      compare("R8 stop on eof");

      // R9: stop mode 2 halts when a word completes while full
      stop_mode = 2'd2; eof_count = 12'd100;
      restart();
      put(4, !ws_pol);
      for (int f = 0; f < 4; f++) begin
         add_std(8, 10, 32'(8'h60 + f * 2), 32'(8'h61 + f * 2));
      end
      put(3, !ws_pol);
      expect_w(32'h60, 4'd0, 1'b0);
      expect_w(32'h61, 4'd1, 1'b0);
      fork
         play();
         begin
            wait (mon_n == base + 2);
            buf_full = 1'b1;
         end
      join
      compare("R9 stop on full");
      buf_full = 1'b0;

      // R7: mode 0 stops when start falls
      stop_mode = 2'd0;
      restart();
      put(4, !ws_pol);
      for (int f = 0; f < 4; f++) begin
         add_std(8, 10, 32'(8'h80 + f * 2), 32'(8'h81 + f * 2));
      end
      put(3, !ws_pol);
      expect_w(32'h80, 4'd0, 1'b0);
      expect_w(32'h81, 4'd1, 1'b0);
      fork
         play();
         begin
            wait (mon_n == base + 2);
            start = 1'b0;
         end
      join
      compare("R7 stop on start low");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule